// File: doc/BRIEF.md
# Parallel Display Bus Engine

This block runs an 8-bit or 16-bit parallel command/data bus towards an external display controller. Software starts a transfer by choosing direction (write or read), whether the beats are command or data, the bus width, the beat count and the strobe timing. Write words come in on a 32-bit valid/ready stream and are cut into bus beats. Read beats are collected into 32-bit words and leave on a second valid/ready stream.

Every beat is timed in bus ticks. A tick is the core clock divided by 1 to 8. Within a beat, the strobe goes active one tick after the beat begins. It stays active for a programmable number of ticks, and then a programmable recovery interval finishes the beat. Chip select stays low for the whole transfer and returns high after the final beat.

Back-pressure works as follows. The engine raises `tx_ready` only when it holds no write word. If `tx_valid` is low, the bus waits with both strobes high and starts no beat. A read word stays on `rx_data` with `rx_valid` high until `rx_ready` accepts it, and no further read beat begins in that time. The upstream side may hold `tx_valid` low for any length of time. Downstream may hold `rx_ready` low for any length of time.

Top module: `pbus_engine`

## Requirements
- R1: One bus tick lasts D = `cfg_div`+1 core clocks. The active strobe (`bus_we_n` or `bus_re_n` low) lasts A×D clocks, where A = `cfg_act`+1.
- R2: Within one beat, the strobe falls exactly one tick after the beat begins. The beat then lasts A+R ticks in total, where R = `cfg_rest`+1. Two consecutive beats cut from the same write word fall (A+R)×D+1 clocks apart.
- R3: If `cfg_rest` < 2 (recovery shorter than 3 ticks), `cfg_err` reads 1 and `start` is ignored: `busy` and all strobes stay inactive and `bus_cs_n` stays high.
- R4: A transfer runs exactly `start_len`+1 beats. `bus_cs_n` then returns high and `busy` falls.
- R5: `bus_dc` is 0 for a command transfer (`start_dc`=0) and 1 for a data transfer. It is held for the whole transfer.
- R6: `bus_cs_n`, `bus_we_n` and `bus_re_n` are active low. `bus_cs_n` is low whenever a strobe is low. The two strobes are never low together.
- R7: Beats are cut from a 32-bit word starting at the least significant lane. With `start_wide`=0 there are 4 beats per word of 8 bits each (driven on `bus_dq_o[7:0]`). With `start_wide`=1 there are 2 beats per word of 16 bits each.
- R8: When the transfer ends partway through a word, the unused write lanes are discarded. A final partial read word is delivered with its unfilled upper lanes set to zero.
- R9: Read data on `bus_dq_i` is sampled one tick after the read strobe rises and is packed lane by lane, starting at the least significant lane. `rx_valid` and `rx_data` hold until `rx_ready`. No read beat begins while a word is waiting.
- R10: While no write word is held (`tx_ready`=1), `bus_we_n` stays high. Beats resume once the next word is accepted.
- R11: `wr_drained` is 0 from the start of a write transfer until its last beat completes, and 1 at all other times.
- R12: After reset the block is idle: `busy`=0, `bus_cs_n`=`bus_we_n`=`bus_re_n`=1, `tx_ready`=0, `rx_valid`=0, `wr_drained`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 3 | Tick divider minus one |
| cfg_act | input | 4 | Strobe active ticks minus one |
| cfg_rest | input | 6 | Recovery ticks minus one, minimum 2 |
| cfg_err | output | 1 | Recovery setting invalid |
| start | input | 1 | Start pulse, sampled when idle |
| start_rd | input | 1 | 1 = read transfer, 0 = write |
| start_dc | input | 1 | 0 = command, 1 = data |
| start_wide | input | 1 | 0 = 8-bit beats, 1 = 16-bit beats |
| start_len | input | 18 | Beat count minus one |
| busy | output | 1 | Transfer in progress |
| wr_drained | output | 1 | No write beats outstanding |
| tx_data | input | 32 | Write word |
| tx_valid | input | 1 | Write word valid |
| tx_ready | output | 1 | Engine takes the write word |
| rx_data | output | 32 | Read word |
| rx_valid | output | 1 | Read word valid |
| rx_ready | input | 1 | Consumer takes the read word |
| bus_dq_o | output | 16 | Bus data out |
| bus_dq_oe | output | 1 | Bus data output enable |
| bus_dq_i | input | 16 | Bus data in |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Command (0) / data (1) select |

## Verification
The hardest state to reach from the ports is a read transfer paused with a filled word waiting and beats still left to run, which then ends on a partial word. The bench holds `rx_ready` low for a fixed window from the start of a six-beat 8-bit read. It counts the read strobes seen while that window is open to show that the bus stopped after one full word. It then releases `rx_ready` and checks that the zero-padded second word arrives. A similar window on `tx_valid` in the middle of a write shows the write strobe staying idle through the stall.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int DIV_W  = 3;
  localparam int ACT_W  = 4;
  localparam int REST_W = 6;
  localparam logic [REST_W-1:0] REST_MIN_CODE = REST_W'(2);

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [ACT_W-1:0]  act;
    logic [REST_W-1:0] rest;
    logic              wide;
    logic              rd;
    logic              dc;
  } xfer_cfg_t;
endpackage

// File: rtl/pbus_tick_div.sv
module pbus_tick_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R1: with a divider above one, ticks are never back to back
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && run) |=> !tick);
endmodule

// File: rtl/pbus_beat_seq.sv
module pbus_beat_seq #(
  parameter int ACT_W  = 4,
  parameter int REST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tick,
  input  logic [ACT_W-1:0]  act,
  input  logic [REST_W-1:0] rest,
  output logic              active,
  output logic              strobe,
  output logic              capture,
  output logic              done
);
  localparam int PH_W = ((ACT_W > REST_W) ? ACT_W : REST_W) + 2;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] act_end;
  logic [PH_W-1:0] last_ph;

  assign act_end = PH_W'(act) + PH_W'(1);
  assign last_ph = PH_W'(act) + PH_W'(rest) + PH_W'(1);

  assign strobe  = active && (ph_q != '0) && (ph_q <= act_end);
  assign capture = active && tick && (ph_q == act_end + PH_W'(1));
  assign done    = active && tick && (ph_q == last_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph_q   <= '0;
    end else if (go) begin
      active <= 1'b1;
      ph_q   <= '0;
    end else if (active && tick) begin
      if (ph_q == last_ph) active <= 1'b0;
      else                 ph_q   <= ph_q + 1'b1;
    end
  end

  // R3: an accepted recovery setting keeps the sample tick apart from the beat end
  p_capture_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !done);
  // R2: a finished beat leaves the sequencer idle for at least one clock
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
endmodule

// File: rtl/pbus_lane_mux.sv
module pbus_lane_mux #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [WORD_W-1:0] tx_word,
  input  logic [LANE_W-1:0] lane,
  input  logic              wide,
  output logic [15:0]       dq,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [15:0]       din,
  output logic [WORD_W-1:0] rx_next
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;

  logic [7:0]  bytes [N8];
  logic [15:0] halves[N16];

  for (genvar b = 0; b < N8; b++) begin : g_byte
    assign bytes[b] = tx_word[b*8 +: 8];
  end
  for (genvar h = 0; h < N16; h++) begin : g_half
    assign halves[h] = tx_word[h*16 +: 16];
  end

  always_comb begin
    dq = 16'h0;
    for (int b = 0; b < N8; b++)
      if (!wide && lane == LANE_W'(b)) dq = {8'h00, bytes[b]};
    for (int h = 0; h < N16; h++)
      if (wide && lane == LANE_W'(h)) dq = halves[h];
  end

  always_comb begin
    rx_next = (lane == '0) ? '0 : rx_word;
    for (int b = 0; b < N8; b++)
      if (!wide && lane == LANE_W'(b)) rx_next[b*8 +: 8] = din[7:0];
    for (int h = 0; h < N16; h++)
      if (wide && lane == LANE_W'(h)) rx_next[h*16 +: 16] = din;
  end
endmodule

// File: rtl/pbus_engine.sv
module pbus_engine
  import pbus_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [ACT_W-1:0]  cfg_act,
  input  logic [REST_W-1:0] cfg_rest,
  output logic              cfg_err,
  input  logic              start,
  input  logic              start_rd,
  input  logic              start_dc,
  input  logic              start_wide,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              wr_drained,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [15:0]       bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [15:0]       bus_dq_i,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_re_n,
  output logic              bus_dc
);
  localparam int LANES8  = WORD_W / 8;
  localparam int LANES16 = WORD_W / 16;
  localparam int LANE_W  = $clog2(LANES8);

  xfer_cfg_t         cfg_q;
  logic [LEN_W-1:0]  left_q;
  logic [LANE_W-1:0] lane_q;
  logic              held_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] rx_word_q;
  logic [WORD_W-1:0] rx_next;

  logic tick, active, strobe, capture, done;
  logic go, start_ok, last_lane, last_beat, word_end;

  assign cfg_err   = (cfg_rest < REST_MIN_CODE);
  assign start_ok  = start && !busy && !rx_valid && !cfg_err;
  assign last_lane = cfg_q.wide ? (lane_q == LANE_W'(LANES16 - 1))
                                : (lane_q == LANE_W'(LANES8 - 1));
  assign last_beat = (left_q == '0);
  assign word_end  = last_lane || last_beat;
  assign go        = busy && !active && (cfg_q.rd ? !rx_valid : held_q);

  assign tx_ready   = busy && !cfg_q.rd && !held_q;
  assign wr_drained = !(busy && !cfg_q.rd);
  assign bus_cs_n   = !busy;
  assign bus_we_n   = !(strobe && !cfg_q.rd);
  assign bus_re_n   = !(strobe && cfg_q.rd);
  assign bus_dc     = cfg_q.dc;
  assign bus_dq_oe  = busy && !cfg_q.rd;
  assign rx_data    = rx_word_q;

  pbus_tick_div #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active), .div(cfg_q.div), .tick(tick)
  );

  pbus_beat_seq #(.ACT_W(ACT_W), .REST_W(REST_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
    .act(cfg_q.act), .rest(cfg_q.rest),
    .active(active), .strobe(strobe), .capture(capture), .done(done)
  );

  pbus_lane_mux #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lanes (
    .tx_word(word_q), .lane(lane_q), .wide(cfg_q.wide), .dq(bus_dq_o),
    .rx_word(rx_word_q), .din(bus_dq_i), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cfg_q     <= '{div: '0, act: '0, rest: REST_MIN_CODE,
                     wide: 1'b0, rd: 1'b0, dc: 1'b1};
      left_q    <= '0;
      lane_q    <= '0;
      held_q    <= 1'b0;
      word_q    <= '0;
      rx_word_q <= '0;
      rx_valid  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (tx_valid && tx_ready) begin
        word_q <= tx_data;
        held_q <= 1'b1;
      end
      if (start_ok) begin
        busy   <= 1'b1;
        cfg_q  <= '{div: cfg_div, act: cfg_act, rest: cfg_rest,
                    wide: start_wide, rd: start_rd, dc: start_dc};
        left_q <= start_len;
        lane_q <= '0;
        held_q <= 1'b0;
      end
      if (capture && cfg_q.rd) rx_word_q <= rx_next;
      if (done) begin
        lane_q <= word_end ? '0 : lane_q + 1'b1;
        if (word_end && !cfg_q.rd) held_q   <= 1'b0;
        if (word_end &&  cfg_q.rd) rx_valid <= 1'b1;
        if (last_beat) busy   <= 1'b0;
        else           left_q <= left_q - 1'b1;
      end
    end
  end

  // R6: any strobe lies inside the chip-select frame
  p_cs_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n || !bus_re_n) |-> !bus_cs_n);
  // R6: read and write strobes exclusive
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_re_n));
  // R9: a waiting read word is held unchanged
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R3: a start with short recovery is refused
  p_bad_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_rest < REST_MIN_CODE) |=> !busy);
  // R10: no write strobe while waiting for a word
  p_stall_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bus_we_n);
  // R11: outstanding writes only inside a frame
  p_drain_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drained |-> !bus_cs_n);
endmodule

// File: tb/pbus_engine_bench.sv
`timescale 1ns/1ps
module pbus_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_div = '0;
  logic [3:0]  cfg_act = '0;
  logic [5:0]  cfg_rest = 6'd2;
  logic        cfg_err;
  logic        start = 1'b0, start_rd = 1'b0, start_dc = 1'b0, start_wide = 1'b0;
  logic [17:0] start_len = '0;
  logic        busy, wr_drained;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [31:0] rx_data;
  logic        rx_valid, rx_ready = 1'b1;
  logic [15:0] bus_dq_o, bus_dq_i = '0;
  logic        bus_dq_oe, bus_cs_n, bus_we_n, bus_re_n, bus_dc;

  always #2.5 clk = ~clk;

  pbus_engine u_pbus_engine (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_act(cfg_act),
    .cfg_rest(cfg_rest), .cfg_err(cfg_err), .start(start), .start_rd(start_rd),
    .start_dc(start_dc), .start_wide(start_wide), .start_len(start_len),
    .busy(busy), .wr_drained(wr_drained), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_dc(bus_dc)
  );

  int checks = 0, errors = 0, cyc = 0;
  // monitor state
  int we_falls, re_falls, low_cnt, lw_min, lw_max, since_fall, per_min;
  int wr_n, dc_bad, wd_bad, rd_k;
  bit have_fall, prev_low, prev_we_low, exp_dc, rd_wide;
  logic [15:0] held_dq;
  logic [15:0] wr_beats [0:31];
  // stream state
  logic [31:0] tx_words [0:7];
  logic [31:0] rx_got   [0:7];
  int tx_n, tx_idx, stall_cnt, falls_at_stall, rx_n, rx_hold, rfalls_at_release;
  bit pend_tx, stall_first;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_pat(input int k, input bit w);
    return w ? 16'(16'h1000 + k) : {8'h00, 8'(8'hA0 + k)};
  endfunction

  always @(negedge clk) begin
    bit low;
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    low = !bus_we_n || !bus_re_n;
    since_fall++;
    if (low) begin
      low_cnt++;
      if (!bus_we_n) held_dq = bus_dq_o;
    end
    if (low && !prev_low) begin
      if (!bus_we_n) we_falls++; else re_falls++;
      if (have_fall && since_fall < per_min) per_min = since_fall;
      have_fall = 1; since_fall = 0;
      if (bus_dc !== exp_dc) dc_bad++;
      if (!bus_re_n) begin bus_dq_i = rd_pat(rd_k, rd_wide); rd_k++; end
    end
    if (!low && prev_low) begin
      if (low_cnt < lw_min) lw_min = low_cnt;
      if (low_cnt > lw_max) lw_max = low_cnt;
      low_cnt = 0;
      if (prev_we_low && wr_n < 32) begin wr_beats[wr_n] = held_dq; wr_n++; end
    end
    if (!bus_we_n && wr_drained) wd_bad++;
    if (!bus_re_n && !wr_drained) wd_bad++;
    prev_low = low; prev_we_low = !bus_we_n;
    // write feeder
    if (pend_tx) begin
      tx_idx++;
      if (tx_idx == 1 && stall_first) stall_cnt = 80;
    end
    if (stall_cnt > 0) begin
      stall_cnt--;
      if (stall_cnt == 0) falls_at_stall = we_falls;
    end
    tx_valid = (tx_idx < tx_n) && (stall_cnt == 0);
    tx_data  = tx_words[tx_idx % 8];
    pend_tx  = tx_valid && tx_ready;
    // read collector
    if (rx_hold > 0) begin
      rx_hold--;
      if (rx_hold == 0) rfalls_at_release = re_falls;
    end
    rx_ready = (rx_hold == 0);
    if (rx_valid && rx_ready && rx_n < 8) begin rx_got[rx_n] = rx_data; rx_n++; end
  end

  task automatic clear_stats();
    @(posedge clk);
    we_falls = 0; re_falls = 0; low_cnt = 0; lw_min = 1000000; lw_max = 0;
    since_fall = 0; per_min = 1000000; have_fall = 0; wr_n = 0; dc_bad = 0;
    wd_bad = 0; rd_k = 0; tx_n = 0; tx_idx = 0; stall_cnt = 0; stall_first = 0;
    falls_at_stall = -1; rx_n = 0; rx_hold = 0; rfalls_at_release = -1;
  endtask

  task automatic run_xfer(input bit rd, input bit dc, input bit wide, input logic [2:0] dv,
                          input logic [3:0] ac, input logic [5:0] rs, input logic [17:0] len);
    int guard = 0;
    exp_dc = dc; rd_wide = wide;
    @(negedge clk);
    cfg_div = dv; cfg_act = ac; cfg_rest = rs;
    start_rd = rd; start_dc = dc; start_wide = wide; start_len = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while ((busy || rx_valid || rx_hold > 0) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 busy", busy, 0);
    chk("R12 cs_n", bus_cs_n, 1);
    chk("R12 we_n/re_n", {bus_we_n, bus_re_n}, 2'b11);
    chk("R12 tx_ready", tx_ready, 0);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 wr_drained", wr_drained, 1);
  endtask

  task automatic t_cmd_narrow();
    clear_stats();
    tx_words[0] = 32'h44332211; tx_words[1] = 32'h88776655; tx_n = 2;
    run_xfer(0, 0, 0, 3'd0, 4'd1, 6'd2, 18'd7);
    chk("R4 beat count", we_falls, 8);
    chk("R4 cs_n after end", bus_cs_n, 1);
    for (int i = 0; i < 8; i++) chk("R7 narrow lane order", wr_beats[i], 32'(8'h11 * (i + 1)));
    chk("R1 low width D=1 A=2", lw_min, 2);
    chk("R1 low width max", lw_max, 2);
    chk("R2 beat period", per_min, 6);
    chk("R5 command select low", dc_bad, 0);
    chk("R11 drained low during write", wd_bad, 0);
    chk("R11 drained after write", wr_drained, 1);
    chk("R6 no read strobe on write", re_falls, 0);
  endtask

  task automatic t_data_wide();
    clear_stats();
    tx_words[0] = 32'hBBBBAAAA; tx_words[1] = 32'hDDDDCCCC; tx_n = 2;
    run_xfer(0, 1, 1, 3'd2, 4'd3, 6'd4, 18'd2);
    chk("R4 wide beat count", we_falls, 3);
    chk("R7 wide beat0", wr_beats[0], 16'hAAAA);
    chk("R7 wide beat1", wr_beats[1], 16'hBBBB);
    chk("R8 partial word beat", wr_beats[2], 16'hCCCC);
    chk("R8 words consumed", tx_idx, 2);
    chk("R1 low width D=3 A=4", lw_min, 12);
    chk("R1 low width max", lw_max, 12);
    chk("R2 beat period D=3", per_min, 28);
    chk("R5 data select high", dc_bad, 0);
  endtask

  task automatic t_bad_rest();
    clear_stats();
    exp_dc = 1;
    @(negedge clk);
    cfg_rest = 6'd1; start_rd = 0; start_len = 18'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 cfg_err", cfg_err, 1);
    repeat (20) @(negedge clk);
    chk("R3 busy stays low", busy, 0);
    chk("R3 cs_n stays high", bus_cs_n, 1);
    chk("R3 no strobe", we_falls + re_falls, 0);
    cfg_rest = 6'd2;
    @(negedge clk);
    chk("R3 cfg_err clear", cfg_err, 0);
  endtask

  task automatic t_tx_stall();
    clear_stats();
    tx_words[0] = 32'h04030201; tx_words[1] = 32'h08070605; tx_n = 2; stall_first = 1;
    run_xfer(0, 1, 0, 3'd0, 4'd1, 6'd2, 18'd7);
    chk("R10 beats during stall", falls_at_stall, 4);
    chk("R10 total beats", we_falls, 8);
    for (int i = 0; i < 8; i++) chk("R10 data after resume", wr_beats[i], 32'(i + 1));
  endtask

  task automatic t_rd_backpressure();
    clear_stats();
    rx_hold = 60;
    run_xfer(1, 1, 0, 3'd0, 4'd0, 6'd2, 18'd5);
    chk("R9 beats while word waits", rfalls_at_release, 4);
    chk("R4 read beats", re_falls, 6);
    chk("R9 words", rx_n, 2);
    chk("R9 first word", rx_got[0], 32'hA3A2A1A0);
    chk("R8 padded word", rx_got[1], 32'h0000A5A4);
    chk("R1 read low width", lw_max, 1);
    chk("R11 drained during read", wd_bad, 0);
    chk("R6 no write strobe on read", we_falls, 0);
  endtask

  task automatic t_rd_wide();
    clear_stats();
    run_xfer(1, 1, 1, 3'd7, 4'd0, 6'd2, 18'd3);
    chk("R9 wide words", rx_n, 2);
    chk("R9 wide word0", rx_got[0], 32'h10011000);
    chk("R9 wide word1", rx_got[1], 32'h10031002);
    chk("R1 read low width D=8", lw_min, 8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_narrow();
    t_data_wide();
    t_bad_rest();
    t_tx_stall();
    t_rd_backpressure();
    t_rd_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule